// File: doc/BRIEF.md
# Prioritised 64-Source Interrupt Controller

This block gathers 64 level-sensitive interrupt request lines and presents a single winner to the processor as a priority level and a vector number. Every source owns a one-byte priority level, a pending bit that tracks its input line, a software force bit, a mask bit and an enable flag. A source competes only when it is requested (by its line or by its force bit), enabled and unmasked. The winner is the competing source with the largest level. On equal levels, the higher source number wins.

Software reaches the state through a small register bus with byte offsets and a 32-bit data path. The pending, mask and force vectors are each split into an upper and a lower 32-bit word. The level bytes form a window of 64 consecutive offsets, one byte per source. Two command offsets set or clear a single mask bit. The bit is named by the low six bits of the written data. A software acknowledge offset returns the vector currently presented to the processor. Reads are combinational on the address. Writes take effect at the clock edge on which the write strobe is high.

Top module: `irqc_top`

## Requirements
- R1: A source is active when (pending OR force) AND enabled AND NOT masked. Only active sources take part in selection.
- R2: Among the active sources, the one with the largest level wins. When levels are equal, the higher source number wins.
- R3: With a winner, `cpu_level` is its level and `cpu_vector` is its number plus 64. With no active source, `cpu_level` is 0 and `cpu_vector` is 24.
- R4: Offset 0x40+n reads and writes the level byte of source n in data bits 7:0. Writing 0 clears the source's enable flag. Writing a nonzero value sets the flag and stores the value.
- R5: Pending bits 63:32 read at offset 0x00 and bits 31:0 read at offset 0x04. Writes to either offset change nothing.
- R6: The mask reads and writes at 0x08 (bits 63:32) and 0x0C (bits 31:0). The force vector reads and writes at 0x10 (bits 63:32) and 0x14 (bits 31:0). A write to one half leaves the other half unchanged.
- R7: A write to offset 0x1C sets the mask bit numbered by data bits 5:0. A write to offset 0x1D clears that bit. Higher data bits are ignored.
- R8: A read of offset 0xE0 returns `cpu_vector` zero-extended to 32 bits.
- R9: After reset, every mask bit is 1. All force bits, enable flags, levels and pending bits are 0. The outputs are level 0 and vector 24.
- R10: A read of any offset not listed above returns 0.
- R11: A change on an input line reaches the outputs after two clock edges: one edge to latch pending, one edge to register the outputs. A register write reaches the outputs one edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 64 | Level-sensitive request lines, bit n is source n |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe, acts at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| cpu_level | output | 8 | Registered priority level of the winner, 0 when idle |
| cpu_vector | output | 8 | Registered vector of the winner, 24 when idle |

## Verification
On every cycle, the assertions check several relations. The idle pairing of level 0 with vector 24 always holds. A nonzero level always comes with a vector in the 64 to 127 range. The acknowledge offset reads back the presented vector. The pending words follow the lines one edge late. Each set-mask, clear-mask and level write lands on the addressed bit. Only the bench's scenarios can show that the right source wins. These scenarios cover ties between equal levels, masking and forcing, disabling a source with a zero level, the two-edge latency, writes that must be ignored, and half-word writes that leave the other half alone. The bench compares each of these with its own model of the requirements.

// File: rtl/irqc_pkg.sv
// Shared constants for the interrupt controller: sizes, offsets and
// fixed vector values. Assumes exactly 64 sources split in two 32-bit words.
package irqc_pkg;
    localparam int NUM_SRC  = 64;
    localparam int LVL_W    = 8;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;
    localparam int VEC_W    = 8;
    localparam int IDX_W    = $clog2(NUM_SRC);

    localparam logic [VEC_W-1:0] VEC_BASE  = 8'd64;
    localparam logic [VEC_W-1:0] VEC_IDLE  = 8'd24;

    localparam logic [ADDR_W-1:0] OFF_PEND_HI  = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_PEND_LO  = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_MASK_HI  = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_MASK_LO  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_FORCE_HI = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_FORCE_LO = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_MSET     = 8'h1C;
    localparam logic [ADDR_W-1:0] OFF_MCLR     = 8'h1D;
    localparam logic [ADDR_W-1:0] OFF_SWACK    = 8'hE0;
    localparam logic [1:0]        LVL_WIN_TAG  = 2'b01;  // offsets 0x40..0x7F

    typedef logic [NUM_SRC-1:0][LVL_W-1:0] lvl_arr_t;
endpackage

// File: rtl/irqc_pending.sv
// Pending latch: registers the request lines once per clock.
// Assumes the lines are already synchronous to clk.
module irqc_pending
    import irqc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] lines,
    output logic [NUM_SRC-1:0] pend
);
    // Sample the lines; a pending bit sets and clears with its line.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= lines;
    end
endmodule

// File: rtl/irqc_regs.sv
// Software-visible state: mask, force, enable flags and level bytes.
// Assumes writes are single-cycle strobes; pending offsets are read-only.
module irqc_regs
    import irqc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [NUM_SRC-1:0] mask,
    output logic [NUM_SRC-1:0] frc,
    output logic [NUM_SRC-1:0] enable,
    output lvl_arr_t           level
);
    localparam int HALF = NUM_SRC / 2;

    logic [IDX_W-1:0] cmd_bit;
    logic [IDX_W-1:0] lvl_idx;
    logic             lvl_hit;

    // Decode the bit number of a mask command and the level window.
    always_comb begin
        cmd_bit = wdata[IDX_W-1:0];
        lvl_idx = addr[IDX_W-1:0];
        lvl_hit = (addr[ADDR_W-1:ADDR_W-2] == LVL_WIN_TAG);
    end

    // Mask: half-word writes plus single-bit set and clear commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '1;
        end else if (wr) begin
            case (addr)
                OFF_MASK_HI: mask[NUM_SRC-1:HALF] <= wdata;
                OFF_MASK_LO: mask[HALF-1:0]       <= wdata;
                OFF_MSET:    mask[cmd_bit]        <= 1'b1;
                OFF_MCLR:    mask[cmd_bit]        <= 1'b0;
                default:     ;
            endcase
        end
    end

    // Force: half-word writes only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frc <= '0;
        end else if (wr) begin
            case (addr)
                OFF_FORCE_HI: frc[NUM_SRC-1:HALF] <= wdata;
                OFF_FORCE_LO: frc[HALF-1:0]       <= wdata;
                default:      ;
            endcase
        end
    end

    // Level bytes and enable flags, one pair per source.
    generate
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    level[s]  <= '0;
                    enable[s] <= 1'b0;
                end else if (wr && lvl_hit && (lvl_idx == IDX_W'(s))) begin
                    level[s]  <= wdata[LVL_W-1:0];
                    enable[s] <= (wdata[LVL_W-1:0] != '0);
                end
            end
        end
    endgenerate
endmodule

// File: rtl/irqc_resolve.sv
// Priority resolution: finds the active source with the largest level,
// the higher number winning ties. Purely combinational.
module irqc_resolve
    import irqc_pkg::*;
(
    input  logic [NUM_SRC-1:0] pend,
    input  logic [NUM_SRC-1:0] frc,
    input  logic [NUM_SRC-1:0] enable,
    input  logic [NUM_SRC-1:0] mask,
    input  lvl_arr_t           level,
    output logic               found,
    output logic [LVL_W-1:0]   win_lvl,
    output logic [IDX_W-1:0]   win_idx
);
    logic [NUM_SRC-1:0] active;

    // Qualify each source.
    always_comb active = (pend | frc) & enable & ~mask;

    // Ascending scan with >= lets a later equal-level source take over.
    always_comb begin
        found   = 1'b0;
        win_lvl = '0;
        win_idx = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (active[i] && (level[i] >= win_lvl)) begin
                found   = 1'b1;
                win_lvl = level[i];
                win_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irqc_readmux.sv
// Read data selection by byte offset; unmapped offsets give zero.
module irqc_readmux
    import irqc_pkg::*;
(
    input  logic [ADDR_W-1:0]  addr,
    input  logic [NUM_SRC-1:0] pend,
    input  logic [NUM_SRC-1:0] mask,
    input  logic [NUM_SRC-1:0] frc,
    input  lvl_arr_t           level,
    input  logic [VEC_W-1:0]   vector,
    output logic [DATA_W-1:0]  rdata
);
    localparam int HALF = NUM_SRC / 2;

    // Select the word addressed by the bus.
    always_comb begin
        rdata = '0;
        if (addr[ADDR_W-1:ADDR_W-2] == LVL_WIN_TAG) begin
            rdata = DATA_W'(level[addr[IDX_W-1:0]]);
        end else begin
            case (addr)
                OFF_PEND_HI:  rdata = pend[NUM_SRC-1:HALF];
                OFF_PEND_LO:  rdata = pend[HALF-1:0];
                OFF_MASK_HI:  rdata = mask[NUM_SRC-1:HALF];
                OFF_MASK_LO:  rdata = mask[HALF-1:0];
                OFF_FORCE_HI: rdata = frc[NUM_SRC-1:HALF];
                OFF_FORCE_LO: rdata = frc[HALF-1:0];
                OFF_SWACK:    rdata = DATA_W'(vector);
                default:      rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/irqc_top.sv
// Top of the interrupt controller: pending latch, register file,
// resolver and read mux, with registered level and vector outputs.
// Assumes a single clock domain and synchronous active-low reset.
module irqc_top
    import irqc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [63:0]        irq_in,
    input  logic [7:0]         bus_addr,
    input  logic               bus_wr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [7:0]         cpu_level,
    output logic [7:0]         cpu_vector
);
    logic [NUM_SRC-1:0] pend_w, mask_w, frc_w, en_w;
    lvl_arr_t           lvl_w;
    logic               found_w;
    logic [LVL_W-1:0]   win_lvl_w;
    logic [IDX_W-1:0]   win_idx_w;

    irqc_pending u_pend (
        .clk(clk), .rst_n(rst_n), .lines(irq_in), .pend(pend_w)
    );

    irqc_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .mask(mask_w), .frc(frc_w),
        .enable(en_w), .level(lvl_w)
    );

    irqc_resolve u_res (
        .pend(pend_w), .frc(frc_w), .enable(en_w), .mask(mask_w),
        .level(lvl_w), .found(found_w), .win_lvl(win_lvl_w),
        .win_idx(win_idx_w)
    );

    irqc_readmux u_rmux (
        .addr(bus_addr), .pend(pend_w), .mask(mask_w), .frc(frc_w),
        .level(lvl_w), .vector(cpu_vector), .rdata(bus_rdata)
    );

    // Register the winner; fall back to the idle vector when none is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_level  <= '0;
            cpu_vector <= VEC_IDLE;
        end else if (found_w) begin
            cpu_level  <= win_lvl_w;
            cpu_vector <= VEC_BASE + VEC_W'(win_idx_w);
        end else begin
            cpu_level  <= '0;
            cpu_vector <= VEC_IDLE;
        end
    end
endmodule

// File: rtl/irqc_checker.sv
// Property checker for irqc_top, attached by bind below.
module irqc_checker
    import irqc_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [63:0]        irq_in,
    input logic [7:0]         bus_addr,
    input logic               bus_wr,
    input logic [31:0]        bus_wdata,
    input logic [31:0]        bus_rdata,
    input logic [7:0]         cpu_level,
    input logic [7:0]         cpu_vector,
    input logic [NUM_SRC-1:0] mask,
    input logic [NUM_SRC-1:0] enable
);
    logic armed;

    // Marks that at least one clock edge has passed since time zero.
    always_ff @(posedge clk) armed <= 1'b1;

    // R3: idle outputs pair level 0 with vector 24.
    a_r3_idle_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_level == 8'd0) |-> (cpu_vector == VEC_IDLE));

    // R3: a nonzero level carries a vector in the source range.
    a_r3_vector_range: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_level != 8'd0) |-> (cpu_vector >= 8'd64 && cpu_vector <= 8'd127));

    // R8: acknowledge offset returns the presented vector.
    a_r8_swack: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFF_SWACK) |-> (bus_rdata == {24'd0, cpu_vector}));

    // R5: lower pending word follows the lines one edge late.
    a_r5_pending_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(rst_n) && bus_addr == OFF_PEND_LO)
            |-> (bus_rdata == $past(irq_in[31:0])));

    // R7: set-mask command lands on the addressed bit.
    a_r7_set_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_MSET) |=> mask[$past(bus_wdata[5:0])]);

    // R7: clear-mask command lands on the addressed bit.
    a_r7_clr_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_MCLR) |=> !mask[$past(bus_wdata[5:0])]);

    // R4: a level write sets the enable flag exactly when the byte is nonzero.
    a_r4_enable_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[7:6] == 2'b01)
            |=> (enable[$past(bus_addr[5:0])] == ($past(bus_wdata[7:0]) != 8'd0)));
endmodule

bind irqc_top irqc_checker u_chk (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_level(cpu_level), .cpu_vector(cpu_vector),
    .mask(mask_w), .enable(en_w)
);

// File: tb/irqc_top_bench.sv
// Scoreboard bench: driver tasks push expected items, a monitor compares.
module irqc_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_in = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  cpu_level, cpu_vector;

    irqc_top u_irqc_top (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cpu_level(cpu_level), .cpu_vector(cpu_vector)
    );

    always #4 clk = ~clk;   // 125 MHz

    typedef struct {
        string       req;
        bit          is_read;
        logic [31:0] exp_data;
        logic [7:0]  exp_lvl;
        logic [7:0]  exp_vec;
    } item_t;

    item_t q[$];
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Bench model of the programmed state.
    logic [63:0] m_mask  = '1;
    logic [63:0] m_frc   = '0;
    logic [63:0] m_en    = '0;
    logic [63:0] m_irq   = '0;
    logic [7:0]  m_lvl [64];

    function automatic void model_out(output logic [7:0] l, output logic [7:0] v);
        logic [7:0] bl = 0;
        int bi = -1;
        for (int i = 0; i < 64; i++) begin
            if ((m_irq[i] | m_frc[i]) & m_en[i] & ~m_mask[i] && m_lvl[i] >= bl) begin
                bl = m_lvl[i];
                bi = i;
            end
        end
        if (bi < 0) begin l = 8'd0; v = 8'd24; end
        else        begin l = bl;   v = 8'(bi + 64); end
    endfunction

    task automatic push_out(string req);
        item_t it;
        logic [7:0] l, v;
        model_out(l, v);
        it.req = req; it.is_read = 1'b0; it.exp_data = '0;
        it.exp_lvl = l; it.exp_vec = v;
        q.push_back(it);
    endtask

    task automatic rd(logic [7:0] a, logic [31:0] exp, string req);
        item_t it;
        @(negedge clk);
        bus_addr = a;
        it.req = req; it.is_read = 1'b1; it.exp_data = exp;
        it.exp_lvl = '0; it.exp_vec = '0;
        q.push_back(it);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        if (a[7:6] == 2'b01) begin
            m_lvl[a[5:0]] = d[7:0];
            m_en[a[5:0]]  = (d[7:0] != 0);
        end
        case (a)
            8'h08: m_mask[63:32] = d;
            8'h0C: m_mask[31:0]  = d;
            8'h10: m_frc[63:32]  = d;
            8'h14: m_frc[31:0]   = d;
            8'h1C: m_mask[d[5:0]] = 1'b1;
            8'h1D: m_mask[d[5:0]] = 1'b0;
            default: ;
        endcase
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Write, then expect the outputs one edge after the write edge.
    task automatic wr_chk(logic [7:0] a, logic [31:0] d, string req);
        wr(a, d);
        @(negedge clk);
        push_out(req);
    endtask

    // Drive lines; old outputs still seen after one edge, new after two.
    task automatic lines_chk(logic [63:0] v, string req, bit lat);
        item_t it;
        logic [7:0] l0, v0;
        model_out(l0, v0);
        @(negedge clk);
        irq_in = v;
        m_irq  = v;
        @(negedge clk);
        if (lat) begin
            it.req = "R11"; it.is_read = 1'b0; it.exp_data = '0;
            it.exp_lvl = l0; it.exp_vec = v0;
            q.push_back(it);
        end
        @(negedge clk);
        push_out(req);
    endtask

    // Monitor: pops every pushed item shortly after the negedge.
    always @(negedge clk) begin
        #2;
        while (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            n_checks++;
            if (it.is_read) begin
                if (bus_rdata !== it.exp_data) begin
                    n_fail++;
                    $display("FAIL %s: read 0x%02h got %08h expected %08h",
                             it.req, bus_addr, bus_rdata, it.exp_data);
                end
            end else if (cpu_level !== it.exp_lvl || cpu_vector !== it.exp_vec) begin
                n_fail++;
                $display("FAIL %s: level/vector got %0d/%0d expected %0d/%0d",
                         it.req, cpu_level, cpu_vector, it.exp_lvl, it.exp_vec);
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(8 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] lfsr;
        for (int i = 0; i < 64; i++) m_lvl[i] = 8'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state at the ports.
        @(negedge clk); push_out("R9");
        rd(8'h08, 32'hFFFF_FFFF, "R9");
        rd(8'h0C, 32'hFFFF_FFFF, "R9");
        rd(8'h14, 32'h0, "R9");
        rd(8'h45, 32'h0, "R9");
        rd(8'hE0, 32'd24, "R9 R8");
        // R10: unmapped offsets read zero.
        rd(8'h20, 32'h0, "R10");
        rd(8'hE4, 32'h0, "R10");

        // R4: level write stored, readback in bits 7:0.
        wr(8'h45, 32'hFFFF_FF03);
        rd(8'h45, 32'h0000_0003, "R4");
        // R7: clear-mask command with junk high bits unmasks source 5.
        wr(8'h1D, 32'h0000_00C5);
        rd(8'h0C, 32'hFFFF_FFDF, "R7");
        // R1 R3 R11: line 5 requested.
        lines_chk(64'h20, "R1 R3", 1'b1);
        // R2: equal level on source 10 wins the tie.
        wr(8'h4A, 32'h3);
        wr(8'h1D, 32'd10);
        lines_chk(64'h420, "R2 tie", 1'b1);
        // R2: higher level on source 2 wins.
        wr(8'h42, 32'h7);
        wr(8'h1D, 32'd2);
        lines_chk(64'h424, "R2 level", 1'b0);
        // R5: pending read and ignored writes.
        wr(8'h04, 32'h0);
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h04, 32'h0000_0424, "R5");
        rd(8'h00, 32'h0, "R5");
        // R6 R1: force source 40 through upper halves.
        wr(8'h68, 32'h9);
        wr(8'h08, 32'hFFFF_FEFF);
        rd(8'h0C, m_mask[31:0], "R6 lower mask unchanged");
        wr_chk(8'h10, 32'h0000_0100, "R6 R1 force");
        rd(8'h10, 32'h0000_0100, "R6");
        rd(8'h14, 32'h0, "R6");
        // R8: acknowledge returns vector 104.
        rd(8'hE0, 32'd104, "R8");
        // R7: set-mask with high junk masks source 40.
        wr_chk(8'h1C, 32'hFFFF_FFE8, "R7 set");
        // R4: zero level disables source 2.
        wr_chk(8'h42, 32'h0, "R4 disable");
        rd(8'hE0, 32'd74, "R8");
        // R3: everything quiet gives idle outputs.
        wr(8'h10, 32'h0);
        lines_chk(64'h0, "R3 idle", 1'b1);
        // R2: extremes 0 and 63 tied at 0xFF.
        wr(8'h40, 32'hFF);
        wr(8'h7F, 32'hFF);
        wr(8'h1D, 32'd0);
        wr(8'h1D, 32'd63);
        lines_chk(64'h8000_0000_0000_0001, "R2 extremes", 1'b0);
        rd(8'h00, 32'h8000_0000, "R5");

        // R1 R2: pseudo-random line patterns against the model.
        wr(8'h0C, 32'h0);
        wr(8'h08, 32'h0);
        for (int i = 1; i < 63; i++) wr(8'(8'h40 + i), 32'((i * 37) % 5));
        lfsr = 64'hACE1_1234_5678_9ABD;
        for (int k = 0; k < 40; k++) begin
            lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
            lines_chk(lfsr & {lfsr[31:0], lfsr[63:32]}, "R1 R2 random", 1'b0);
        end

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule